// File: doc/BRIEF.md
# Asymmetric complementary dead-time pair generator

This block turns one reference PWM waveform into a complementary pair of outputs: a main output that follows the reference and a complement output that follows its inverse. Each output turns on only after a programmable gap has passed since the reference edge that calls for it. Each output turns off on the same clock as that edge. The gap keeps the two outputs from ever being high together, which protects a half-bridge from shoot-through.

Each gap is set by an 8-bit code. The code is decoded piecewise into a tick count. In the lowest range a code step is one tick; the higher ranges use steps of 2, 8 and 16 ticks. The gap is counted in ticks of a dead-time clock-enable input, not in raw clocks. There are two codes, one for the gap before the main output turns on and one for the gap before the complement turns on. An asymmetry bit picks whether the second code is used at all. A lock-level input makes the configuration read-only while it is nonzero.

The reference, the tick and the lock level are plain level inputs sampled every clock. The configuration port is a plain single-cycle write strobe. There is no back-pressure anywhere: every write presented while unlocked is taken on that clock.

Top module: `dtpair_gen`

## Requirements
- R1: While reset is asserted both outputs are low. After reset, the lock level is 0 and both codes and the asymmetry bit are 0. With the reference low out of reset, the complement output goes high on the first clock after reset is released.
- R2: `out_main` and `out_comp` are never high in the same cycle.
- R3: A rising reference edge sampled at clock k drives `out_comp` low at clock k. `out_main` then goes high at clock k+D, where D is the decoded rising code, counted with `dt_tick` held high.
- R4: With the asymmetry bit at 0, a falling reference edge sampled at clock k drives `out_main` low at clock k. `out_comp` then goes high at clock k+D, where D is decoded from the rising code.
- R5: With the asymmetry bit at 1, a falling edge uses the falling code for D. The rising edge keeps using the rising code.
- R6: For codes whose bits [7:5] are 0xx, D equals the code value: 0 to 127 ticks in steps of 1.
- R7: For codes whose bits [7:5] are 10x, D = (64 + code[5:0]) x 2, which covers 128 to 254 ticks.
- R8: For codes whose bits [7:5] are 110, D = (32 + code[4:0]) x 8, which covers 256 to 504 ticks.
- R9: For codes whose bits [7:5] are 111, D = (32 + code[4:0]) x 16, which covers 512 to 1008 ticks.
- R10: The gap counter moves only on clocks where `dt_tick` is high. With `dt_tick` low, the pending output stays low for any length of time. It turns on at the clock of the D-th tick.
- R11: If the reference returns to its previous level before the gap has ended, the pending output never turns on during that pulse. The opposite edge starts its own full gap.
- R12: The write port takes `cfg_wdata` on a clock where `cfg_we` is high. Address 0 loads the rising code from bits [7:0]. Address 1 loads the falling code from bits [7:0] and the asymmetry bit from bit 8. A write takes effect on the next clock when `lock_lvl` is 0. The write is ignored when `lock_lvl` is 1, 2 or 3.
- R13: A code of 0 gives no gap. The turning-on output goes high at the same clock k at which the other output goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: rising code, 1: falling code and asymmetry bit |
| cfg_wdata | input | 9 | Write data; bit 8 is the asymmetry bit at address 1 |
| lock_lvl | input | 2 | Write protection level; any nonzero value blocks writes |
| dt_tick | input | 1 | Dead-time clock enable; one gap tick per high cycle |
| pwm_ref | input | 1 | Reference PWM waveform |
| out_main | output | 1 | Main output, turns on after the rising gap |
| out_comp | output | 1 | Complement output, turns on after the falling gap |

## Verification
The bench measures the gap at both ends of every code range: 0x05, 0x7F, 0x80, 0xBF, 0xC1, 0xDF, 0xE0 and 0xFF. A decoder with a wrong range boundary, a wrong step or a wrong base offset gives a gap that is off by a whole step or more. It checks that the falling edge switches codes only when the asymmetry bit is set; a swapped select uses the wrong code on one edge. It sends a pulse shorter than its gap. A counter that is not cleared then either turns on late inside the next pulse or carries stale ticks into the next gap. It holds `dt_tick` low and then hands out single ticks, to catch a counter that runs on raw clocks. It also writes at every nonzero lock level, to catch a lock that is ignored or that only blocks some levels.

// File: rtl/dtpair_pkg.sv
package dtpair_pkg;
  localparam int CODE_W = 8;
  localparam int CNT_W  = 11;
  localparam int LOCK_W = 2;
  localparam int DATA_W = CODE_W + 1;

  typedef enum logic {
    ADDR_RISE = 1'b0,
    ADDR_FALL = 1'b1
  } cfg_addr_e;

  typedef struct packed {
    logic              asym;
    logic [CODE_W-1:0] fall_code;
    logic [CODE_W-1:0] rise_code;
  } dt_cfg_t;
endpackage

// File: rtl/dtpair_cfg_regs.sv
module dtpair_cfg_regs
  import dtpair_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int LW = LOCK_W,
  localparam int DW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] lock_lvl,
  output dt_cfg_t       cfg
);
  logic unlocked;
  assign unlocked = (lock_lvl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we && unlocked) begin
      if (addr == ADDR_RISE) begin
        cfg.rise_code <= wdata[CW-1:0];
      end else begin
        cfg.fall_code <= wdata[CW-1:0];
        cfg.asym      <= wdata[CW];
      end
    end
  end

  // R12: a write at any nonzero lock level leaves every field untouched
  assert_locked_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock_lvl != '0) |=> $stable(cfg));

  // R12: an unlocked write to address 1 lands on the next clock
  assert_fall_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock_lvl == '0 && addr == ADDR_FALL)
      |=> (cfg.fall_code == $past(wdata[CW-1:0]) && cfg.asym == $past(wdata[CW])));
endmodule

// File: rtl/dtpair_code_decode.sv
module dtpair_code_decode
  import dtpair_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NW = CNT_W
) (
  input  logic [CW-1:0] code,
  output logic [NW-1:0] ticks
);
  localparam int MID_BASE  = 64;
  localparam int HIGH_BASE = 32;
  localparam int SH_MID    = 1;
  localparam int SH_HIGH   = 3;
  localparam int SH_TOP    = 4;

  always_comb begin
    casez (code[CW-1:CW-3])
      3'b0??:  ticks = NW'(code[CW-2:0]);
      3'b10?:  ticks = (NW'(code[CW-3:0]) + NW'(MID_BASE)) << SH_MID;
      3'b110:  ticks = (NW'(code[CW-4:0]) + NW'(HIGH_BASE)) << SH_HIGH;
      default: ticks = (NW'(code[CW-4:0]) + NW'(HIGH_BASE)) << SH_TOP;
    endcase
  end
endmodule

// File: rtl/dtpair_edge_channel.sv
module dtpair_edge_channel
  import dtpair_pkg::*;
#(
  parameter int NW = CNT_W,
  parameter int MAX_TICKS = 1008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want,
  input  logic          tick,
  input  logic [NW-1:0] delay,
  output logic          out_q
);
  logic          want_q;
  logic [NW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      cnt    <= '0;
      out_q  <= 1'b0;
    end else begin
      want_q <= want;
      if (!want) begin
        cnt   <= '0;
        out_q <= 1'b0;
      end else if (!want_q) begin
        cnt   <= delay;
        out_q <= (delay == '0);
      end else if (cnt != '0 && tick) begin
        cnt <= cnt - NW'(1);
        if (cnt == NW'(1)) out_q <= 1'b1;
      end
    end
  end

  // R11: once the reference leaves this output's level, the output is off next clock
  assert_off_when_unwanted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !want |=> !out_q);

  // R10: a running gap does not advance on a clock without a tick
  assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (want && want_q && cnt != '0 && !tick) |=> $stable(cnt));

  // R9: the loaded gap never exceeds the largest decodable value
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NW'(MAX_TICKS));
endmodule

// File: rtl/dtpair_gen.sv
module dtpair_gen
  import dtpair_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NW = CNT_W,
  parameter int LW = LOCK_W,
  localparam int DW = CW + 1,
  localparam int MAX_TICKS = ((1 << (CW - 3)) - 1 + 32) * 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [LW-1:0] lock_lvl,
  input  logic          dt_tick,
  input  logic          pwm_ref,
  output logic          out_main,
  output logic          out_comp
);
  localparam int NCH = 2;

  dt_cfg_t cfg;
  logic [NCH-1:0] ch_out;

  dtpair_cfg_regs #(.CW(CW), .LW(LW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .lock_lvl (lock_lvl),
    .cfg      (cfg)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit IS_FALL = (g == 1);
    logic [CW-1:0] code;
    logic [NW-1:0] delay;
    logic          want;

    assign code = (IS_FALL && cfg.asym) ? cfg.fall_code : cfg.rise_code;
    assign want = IS_FALL ? ~pwm_ref : pwm_ref;

    dtpair_code_decode #(.CW(CW), .NW(NW)) u_dec (
      .code  (code),
      .ticks (delay)
    );

    dtpair_edge_channel #(.NW(NW), .MAX_TICKS(MAX_TICKS)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .tick  (dt_tick),
      .delay (delay),
      .out_q (ch_out[g])
    );
  end

  assign out_main = ch_out[0];
  assign out_comp = ch_out[1];

  // R2: the pair is never on together
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_main && out_comp));

  // R3: a high reference drops the complement on the following clock
  assert_comp_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_ref |=> !out_comp);

  // R4: a low reference drops the main output on the following clock
  assert_main_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_ref |=> !out_main);
endmodule

// File: tb/dtpair_gen_tb.sv
module dtpair_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic [1:0] lock_lvl = '0;
  logic       dt_tick = 1'b1;
  logic       pwm_ref = 1'b0;
  logic       out_main, out_comp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dtpair_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lock_lvl(lock_lvl), .dt_tick(dt_tick),
    .pwm_ref(pwm_ref), .out_main(out_main), .out_comp(out_comp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit addr, input logic [8:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive the reference to lvl and measure clocks until the delayed output turns on.
  task automatic meas(input bit lvl, input int exp, input string tag);
    int n = 0;
    bit overlap = 1'b0;
    logic imm, dly;
    @(negedge clk) pwm_ref = lvl;
    @(posedge clk) #1;
    imm = lvl ? out_comp : out_main;
    dly = lvl ? out_main : out_comp;
    chk(imm == 1'b0, {tag, " immediate turn-off"}, int'(imm), 0);
    while (!dly && n < 1200) begin
      @(posedge clk) #1;
      n++;
      dly = lvl ? out_main : out_comp;
      if (out_main && out_comp) overlap = 1'b1;
    end
    chk(n == exp, {tag, " gap length"}, n, exp);
    chk(!overlap, "R2 pair overlap", int'(overlap), 0);
  endtask

  task automatic t_reset();
    @(posedge clk) #1;
    chk(out_main == 0 && out_comp == 0, "R1 outputs low in reset",
        int'({out_main, out_comp}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1;
    chk(out_comp == 1'b1, "R1 complement on after reset with zero config", int'(out_comp), 1);
    meas(1'b1, 0, "R13 zero code rising");
    meas(1'b0, 0, "R13 zero code falling");
  endtask

  task automatic t_code(input logic [7:0] code, input int exp, input string tag);
    wr(1'b1, 9'h000);
    wr(1'b0, {1'b0, code});
    meas(1'b1, exp, {tag, " R3 rising"});
    meas(1'b0, exp, {tag, " R4 falling shared code"});
  endtask

  task automatic t_asym();
    wr(1'b0, 9'h00A);
    wr(1'b1, {1'b1, 8'h03});
    meas(1'b1, 10, "R5 rising keeps rising code");
    meas(1'b0, 3, "R5 falling uses falling code");
  endtask

  task automatic t_lock();
    lock_lvl = 2'd1;
    wr(1'b1, {1'b0, 8'h09});
    meas(1'b1, 10, "R12 lock1 rising");
    meas(1'b0, 3, "R12 lock1 falling write ignored");
    lock_lvl = 2'd2;
    wr(1'b0, 9'h020);
    meas(1'b1, 10, "R12 lock2 rising write ignored");
    meas(1'b0, 0 + 3, "R12 lock2 falling");
    lock_lvl = 2'd3;
    wr(1'b1, {1'b0, 8'h40});
    meas(1'b1, 10, "R12 lock3 rising");
    meas(1'b0, 3, "R12 lock3 falling write ignored");
    lock_lvl = 2'd0;
    wr(1'b1, {1'b1, 8'h06});
    meas(1'b1, 10, "R12 unlocked rising");
    meas(1'b0, 6, "R12 unlocked falling write taken");
  endtask

  task automatic t_short();
    bit seen = 1'b0;
    wr(1'b0, 9'h014);
    wr(1'b1, {1'b1, 8'h05});
    @(negedge clk) pwm_ref = 1'b1;
    repeat (8) begin
      @(posedge clk) #1;
      if (out_main) seen = 1'b1;
    end
    chk(!seen, "R11 main stays off in short pulse", int'(seen), 0);
    meas(1'b0, 5, "R11 falling gap after short pulse");
    repeat (30) begin
      @(posedge clk) #1;
      if (out_main) seen = 1'b1;
    end
    chk(!seen, "R11 main off after short pulse ends", int'(seen), 0);
    meas(1'b1, 20, "R11 full rising gap restarts");
    meas(1'b0, 5, "R11 settle low");
  endtask

  task automatic t_tick();
    bit seen = 1'b0;
    wr(1'b0, 9'h003);
    dt_tick = 1'b0;
    @(negedge clk) pwm_ref = 1'b1;
    repeat (40) begin
      @(posedge clk) #1;
      if (out_main) seen = 1'b1;
    end
    chk(!seen, "R10 no progress without ticks", int'(seen), 0);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk) dt_tick = 1'b1;
      @(negedge clk) dt_tick = 1'b0;
      if (i < 3) chk(out_main == 1'b0, "R10 main off before last tick", int'(out_main), 0);
      else chk(out_main == 1'b1, "R10 main on at third tick", int'(out_main), 1);
      repeat (3) @(negedge clk);
      if (i < 3) chk(out_main == 1'b0, "R10 main holds off between ticks", int'(out_main), 0);
    end
    dt_tick = 1'b1;
    meas(1'b0, 5, "R10 settle low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_code(8'h05, 5, "R6 low");
    t_code(8'h7F, 127, "R6 top");
    t_code(8'h80, 128, "R7 low");
    t_code(8'hBF, 254, "R7 top");
    t_code(8'hC1, 264, "R8 low");
    t_code(8'hDF, 504, "R8 top");
    t_code(8'hE0, 512, "R9 low");
    t_code(8'hFF, 1008, "R9 top");
    t_asym();
    t_lock();
    t_short();
    t_tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule